// File: doc/BRIEF.md
# Priority Interrupt Pending Selector

This block serves one processor. It looks at a set of interrupt sources and chooses the most urgent one that is both enabled and pending. Each source has an enable bit, a pending bit and an 8-bit priority. A smaller priority number means a more urgent interrupt. The block reports the identifier of the source it chose and drives one interrupt request line toward the processor.

Two checks stand between the winner and the processor. First, the winner is reported only if its priority is strictly below the priority mask. Second, the request line rises only if the winner's priority is also strictly below the priority of the interrupt currently being serviced. A global distributor enable and a per-processor interface enable can each silence the block.

Register decoding, trigger handling and the acknowledge and completion handshakes are handled elsewhere; their results arrive here as plain inputs. The choice is made again on every clock, and both outputs are registered.

Top module: `irq_pend_select`

## Requirements
- R1: Among the sources whose enable and pending bits are both set, the reported ID is the one with the numerically smallest priority, provided the enables and the mask allow it to be reported.
- R2: When qualifying sources share the smallest priority, the source with the lowest ID is reported.
- R3: A source with only its enable bit set, or only its pending bit set, never wins and never affects the outputs.
- R4: The reported ID is 1023 when no source qualifies or when the winner's priority is not strictly below the 8-bit priority mask. A mask of 0 therefore blocks everything, and a source at priority 0xFF is never reported.
- R5: The request output is 1 exactly when an ID other than 1023 is reported and the winner's priority is strictly below the 9-bit running priority. A running priority of 0x100 means idle and lets any 8-bit priority through.
- R6: When the distributor enable or the interface enable is 0, the request is 0 and the reported ID is 1023, whatever the sources hold.
- R7: Both outputs are registered. They reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: A synchronous active-high reset forces the reported ID to 1023 and the request to 0 at the next rising edge, and holds them there while reset stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | 1 | Processor interface enable |
| src_en | input | NUM_SRC | Enable bit of each source, bit i belongs to ID i |
| src_pend | input | NUM_SRC | Pending bit of each source, bit i belongs to ID i |
| src_prio | input | NUM_SRC*8 | Priorities packed flat; bits [8i+7:8i] belong to ID i |
| prio_mask | input | 8 | Priority mask; the winner must be strictly below it |
| run_prio | input | 9 | Running priority; 0x100 means nothing is being serviced |
| pend_id | output | 10 | Registered winning ID, or 1023 when nothing is reported |
| irq_req | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume three things about the inputs:
- they are stable around each rising edge;
- reset is high from time zero;
- NUM_SRC stays below 1023, so a real ID can never be mistaken for the no-interrupt code.

The checker keeps its own registered copy of the qualifying bits, the priorities, the mask and the running priority from the previous edge. It then ties each reported ID to the inputs that produced it.

The bench always changes inputs on the falling edge and reads the outputs one falling edge later. Its sweep uses a small configuration with only a few distinct priority values, so ties, mask boundaries and running-priority boundaries come up often.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int PRIO_W = 8;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] NO_IRQ = '1;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;

  // challenger replaces holder only when strictly more urgent
  function automatic logic beats(input cand_t challenger, input cand_t holder);
    return challenger.vld && (!holder.vld || (challenger.prio < holder.prio));
  endfunction

endpackage

// File: rtl/irq_sel_merge.sv
module irq_sel_merge
  import irq_sel_pkg::*;
(
  input  cand_t lo,
  input  cand_t hi,
  output cand_t win
);

  // lo always carries the lower IDs, so it keeps ties
  always_comb begin
    win = beats(hi, lo) ? hi : lo;
  end

endmodule

// File: rtl/irq_sel_tree.sv
module irq_sel_tree
  import irq_sel_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]        qual,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output cand_t                     best
);

  localparam int LVL    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t node [NODES];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NUM_SRC) begin : g_real
      assign node[LEAVES-1+k] = cand_t'{vld:  qual[k],
                                        prio: prio_flat[k*PRIO_W +: PRIO_W],
                                        id:   ID_W'(k)};
    end else begin : g_pad
      assign node[LEAVES-1+k] = cand_t'{vld: 1'b0, prio: '1, id: NO_IRQ};
    end
  end

  // heap layout: node n has children 2n+1 (lower IDs) and 2n+2
  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    irq_sel_merge u_merge (
      .lo  (node[2*n+1]),
      .hi  (node[2*n+2]),
      .win (node[n])
    );
  end

  assign best = node[0];

endmodule

// File: rtl/irq_sel_gate.sv
module irq_sel_gate
  import irq_sel_pkg::*;
(
  input  cand_t             best,
  input  logic              dist_en,
  input  logic              cpu_en,
  input  logic [PRIO_W-1:0] prio_mask,
  input  logic [PRIO_W:0]   run_prio,
  output logic [ID_W-1:0]   nxt_id,
  output logic              nxt_req
);

  logic on;
  logic pass_mask;
  logic pass_run;

  always_comb begin
    on        = dist_en && cpu_en;
    pass_mask = best.vld && (best.prio < prio_mask);
    pass_run  = ({1'b0, best.prio} < run_prio);
    nxt_id    = (on && pass_mask) ? best.id : NO_IRQ;
    nxt_req   = on && pass_mask && pass_run;
  end

endmodule

// File: rtl/irq_pend_select.sv
module irq_pend_select
  import irq_sel_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dist_en,
  input  logic                      cpu_en,
  input  logic [NUM_SRC-1:0]        src_en,
  input  logic [NUM_SRC-1:0]        src_pend,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic [PRIO_W-1:0]         prio_mask,
  input  logic [PRIO_W:0]           run_prio,
  output logic [ID_W-1:0]           pend_id,
  output logic                      irq_req
);

  logic [NUM_SRC-1:0] qual;
  cand_t              best;
  logic [ID_W-1:0]    nxt_id;
  logic               nxt_req;

  assign qual = src_en & src_pend;

  irq_sel_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .qual      (qual),
    .prio_flat (src_prio),
    .best      (best)
  );

  irq_sel_gate u_gate (
    .best      (best),
    .dist_en   (dist_en),
    .cpu_en    (cpu_en),
    .prio_mask (prio_mask),
    .run_prio  (run_prio),
    .nxt_id    (nxt_id),
    .nxt_req   (nxt_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_id <= NO_IRQ;
      irq_req <= 1'b0;
    end else begin
      pend_id <= nxt_id;
      irq_req <= nxt_req;
    end
  end

endmodule

// File: rtl/irq_sel_chk.sv
module irq_sel_chk
  import irq_sel_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      dist_en,
  input logic                      cpu_en,
  input logic [NUM_SRC-1:0]        src_en,
  input logic [NUM_SRC-1:0]        src_pend,
  input logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input logic [PRIO_W-1:0]         prio_mask,
  input logic [PRIO_W:0]           run_prio,
  input logic [ID_W-1:0]           pend_id,
  input logic                      irq_req
);

  logic [NUM_SRC-1:0]        qual_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [PRIO_W-1:0]         mask_q;
  logic [PRIO_W:0]           run_q;
  logic [PRIO_W-1:0]         sel_prio;
  logic                      sel_qual;

  always_ff @(posedge clk) begin
    qual_q <= src_en & src_pend;
    prio_q <= src_prio;
    mask_q <= prio_mask;
    run_q  <= run_prio;
  end

  always_comb begin
    sel_prio = '0;
    sel_qual = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_id == ID_W'(i)) begin
        sel_prio = prio_q[i*PRIO_W +: PRIO_W];
        sel_qual = qual_q[i];
      end
    end
  end

  assert_id_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    (pend_id != NO_IRQ) |-> (pend_id < ID_W'(NUM_SRC)));

  assert_winner_qualified_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_id != NO_IRQ) |-> sel_qual);

  assert_winner_under_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (pend_id != NO_IRQ) |-> (sel_prio < mask_q));

  assert_req_needs_winner_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((pend_id != NO_IRQ) && ({1'b0, sel_prio} < run_q)));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (!dist_en || !cpu_en) |=> ((pend_id == NO_IRQ) && !irq_req));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> ((pend_id == NO_IRQ) && !irq_req));

endmodule

bind irq_pend_select irq_sel_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dist_en   (dist_en),
  .cpu_en    (cpu_en),
  .src_en    (src_en),
  .src_pend  (src_pend),
  .src_prio  (src_prio),
  .prio_mask (prio_mask),
  .run_prio  (run_prio),
  .pend_id   (pend_id),
  .irq_req   (irq_req)
);

// File: tb/sim_irq_pend_select.sv
module sim_irq_pend_select;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             dist_en, cpu_en;
  logic [N-1:0]     en, pd;
  logic [7:0]       pr [N];
  logic [N*8-1:0]   prio_flat;
  logic [7:0]       mask;
  logic [8:0]       run;
  logic [9:0]       pend_id;
  logic             irq_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = pr[i];
  end

  irq_pend_select #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst(rst), .dist_en(dist_en), .cpu_en(cpu_en),
    .src_en(en), .src_pend(pd), .src_prio(prio_flat),
    .prio_mask(mask), .run_prio(run), .pend_id(pend_id), .irq_req(irq_req)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string tag, input logic [9:0] eid, input logic ereq);
    n_cmp++;
    if (pend_id !== eid || irq_req !== ereq) begin
      n_bad++;
      $display("FAIL %s: id=%0d req=%0b expected id=%0d req=%0b",
               tag, pend_id, irq_req, eid, ereq);
    end
  endtask

  task automatic predict(output logic [9:0] eid, output logic ereq);
    int best = 256;
    int bid = -1;
    for (int i = 0; i < N; i++)
      if (en[i] && pd[i] && int'(pr[i]) < best) begin
        best = int'(pr[i]);
        bid = i;
      end
    if (dist_en && cpu_en && bid >= 0 && best < int'(mask)) begin
      eid  = 10'(bid);
      ereq = best < int'(run);
    end else begin
      eid  = 10'd1023;
      ereq = 1'b0;
    end
  endtask

  task automatic step(input string tag);
    logic [9:0] eid;
    logic ereq;
    predict(eid, ereq);
    @(posedge clk);
    @(negedge clk);
    chk(tag, eid, ereq);
  endtask

  task automatic step_fixed(input string tag, input logic [9:0] eid, input logic ereq);
    @(posedge clk);
    @(negedge clk);
    chk(tag, eid, ereq);
  endtask

  task automatic clear();
    dist_en = 1'b1; cpu_en = 1'b1;
    en = '0; pd = '0;
    for (int i = 0; i < N; i++) pr[i] = 8'h80;
    mask = 8'hFF; run = 9'h100;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R7: watchdog expired id=%0d req=%0b expected run to end", pend_id, irq_req);
    report();
    $finish;
  end

  initial begin
    logic [31:0] s;
    rst = 1'b1;
    clear();
    en = '1; pd = '1; pr[2] = 8'h10;
    repeat (3) @(negedge clk);
    chk("R8 reset holds idle", 10'd1023, 1'b0);
    rst = 1'b0;
    step_fixed("R8 leaves reset", 10'd2, 1'b1);
    rst = 1'b1;
    step_fixed("R8 reset reapplied", 10'd1023, 1'b0);
    rst = 1'b0;

    // R3: enable-only or pending-only sources are ignored
    clear(); en = '1;
    step_fixed("R3 enable only", 10'd1023, 1'b0);
    clear(); pd = '1;
    step_fixed("R3 pending only", 10'd1023, 1'b0);
    clear(); en[1] = 1; pr[1] = 8'h01; pd[4] = 1; pr[4] = 8'h02;
    en[6] = 1; pd[6] = 1; pr[6] = 8'h30;
    step_fixed("R3 half-qualified ignored", 10'd6, 1'b1);

    // R1: smallest priority wins
    clear(); en = '1; pd = '1;
    for (int i = 0; i < N; i++) pr[i] = 8'(8'hA0 - 8'(i * 3));
    pr[5] = 8'h05;
    step_fixed("R1 lowest value wins", 10'd5, 1'b1);

    // R2: tie goes to lower ID
    clear(); en[3] = 1; pd[3] = 1; en[6] = 1; pd[6] = 1;
    pr[3] = 8'h40; pr[6] = 8'h40;
    step_fixed("R2 tie lower id", 10'd3, 1'b1);
    en[7] = 1; pd[7] = 1; pr[7] = 8'h40; en[0] = 1; pd[0] = 1; pr[0] = 8'h40;
    step_fixed("R2 tie with id 0", 10'd0, 1'b1);

    // R4: mask boundaries
    clear(); en[4] = 1; pd[4] = 1; pr[4] = 8'h40; mask = 8'h40;
    step_fixed("R4 equal to mask blocked", 10'd1023, 1'b0);
    mask = 8'h41;
    step_fixed("R4 one below mask passes", 10'd4, 1'b1);
    mask = 8'h00; pr[4] = 8'h00;
    step_fixed("R4 mask zero blocks", 10'd1023, 1'b0);
    mask = 8'hFF; pr[4] = 8'hFE;
    step_fixed("R4 0xFE under 0xFF", 10'd4, 1'b1);
    pr[4] = 8'hFF;
    step_fixed("R4 0xFF never reported", 10'd1023, 1'b0);

    // R5: running priority gate
    clear(); en[2] = 1; pd[2] = 1; pr[2] = 8'h20; run = 9'h020;
    step_fixed("R5 equal running no req", 10'd2, 1'b0);
    run = 9'h021;
    step_fixed("R5 below running req", 10'd2, 1'b1);
    run = 9'h000;
    step_fixed("R5 running zero no req", 10'd2, 1'b0);
    pr[2] = 8'hFE; run = 9'h100;
    step_fixed("R5 idle running lets 0xFE", 10'd2, 1'b1);

    // R6: enables
    clear(); en = '1; pd = '1; pr[1] = 8'h01; dist_en = 0;
    step_fixed("R6 distributor off", 10'd1023, 1'b0);
    dist_en = 1; cpu_en = 0;
    step_fixed("R6 interface off", 10'd1023, 1'b0);
    cpu_en = 1;
    step_fixed("R6 both back on", 10'd1, 1'b1);

    // R7: outputs hold until the next rising edge
    pd = '0;
    #1;
    chk("R7 holds before edge", 10'd1, 1'b1);
    @(posedge clk);
    @(negedge clk);
    chk("R7 updates after edge", 10'd1023, 1'b0);

    // sweep with few priority values to provoke ties and boundaries
    s = 32'h1234_5678;
    for (int k = 0; k < 4000; k++) begin
      s = xs(s); en = s[N-1:0] | s[N+7:8]; pd = s[23:16] | s[31:24];
      s = xs(s);
      for (int i = 0; i < N; i++) pr[i] = {s[i*3 +: 3], 5'h00} | {7'h0, s[i]};
      s = xs(s);
      mask = s[2] ? 8'hFF : s[15:8];
      run  = s[3] ? 9'h100 : {1'b0, s[23:16]};
      dist_en = s[27:24] != 4'h0;
      cpu_en  = s[31:28] != 4'h0;
      step("R1 sweep");
    end

    report();
    $finish;
  end

endmodule